// File: doc/BRIEF.md
# Stream Link Monitor

The block is spliced into a valid/ready packet stream whose packets carry either picture data or a short descriptor packet. It adds no logic to the data path. Data, valid, ready and the start/end-of-packet markers pass straight through without registers. On the side it watches the accepted beats. It classifies each packet by the type code in its first beat and counts completed picture packets and descriptor packets separately. It also takes the frame width and height out of descriptor packets.

A small word-addressed register port lets a host read the following:

- the live handshake levels;
- a flag showing that a packet has started and not yet ended, so a stalled, unterminated frame is visible;
- how many cycles that packet has been open;
- the two packet counts;
- the last complete resolution.

A write to the clear address zeroes the counters. The register port has a write strobe, an address and combinational read data; the written value is ignored.

Top module: `stream_link_monitor`

## Requirements
- R1: `m_data`, `m_valid`, `m_sop` and `m_eop` equal `s_data`, `s_valid`, `s_sop` and `s_eop` in the same cycle, and `s_ready` equals `m_ready`; there is no added latency.
- R2: Reading address 0 returns bit 0 = `s_valid`, bit 1 = `m_ready`, bit 2 = packet-open flag, with all other bits zero.
- R3: A beat is accepted only in a cycle with `s_valid` and `m_ready` both high. The type code is bits [3:0] of the accepted start-of-packet beat: 0 marks a picture packet and 0xF a descriptor packet. Other codes are never counted.
- R4: The picture count (address 1) and the descriptor count (address 2) each rise by one on an accepted end-of-packet beat that closes a packet of their type. An end-of-packet beat with no packet open is ignored.
- R5: In a descriptor packet, bits [3:0] of the first eight accepted beats after the header give the width nibbles (most significant first), then the height nibbles (most significant first); nibbles that never arrive read as zero. Address 3 returns width in [15:0] and height in [31:16]. It is updated only when the descriptor packet ends with an accepted end-of-packet beat.
- R6: The open flag is set by an accepted start-of-packet beat without end-of-packet and cleared by any accepted end-of-packet beat. A single-beat packet leaves it clear. A start-of-packet beat while a packet is open abandons the old packet without counting it.
- R7: The duration (address 4) is loaded with 0 when a start-of-packet beat is accepted. It rises by one at every clock edge at which the open flag was set before the edge, and it holds while no packet is open.
- R8: A write to address 5 zeroes both packet counts and the duration, and leaves the captured resolution unchanged. Writes to other addresses change nothing. Reads of address 5 and of unused addresses return 0.
- R9: If a clear write falls in the same cycle as a counted event, the event is applied on top of zero: a closing picture packet leaves the picture count at 1, and an open packet leaves the duration at 1.
- R10: The two packet counts and the duration saturate at all ones (width `CNT_W`).
- R11: After synchronous reset all counts, the duration and the resolution read 0 and the open flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | DATA_W | Upstream data |
| s_valid | input | 1 | Upstream valid |
| s_ready | output | 1 | Ready returned upstream |
| s_sop | input | 1 | Upstream start-of-packet |
| s_eop | input | 1 | Upstream end-of-packet |
| m_data | output | DATA_W | Downstream data |
| m_valid | output | 1 | Downstream valid |
| m_ready | input | 1 | Downstream ready |
| m_sop | output | 1 | Downstream start-of-packet |
| m_eop | output | 1 | Downstream end-of-packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_rdata | output | 32 | Combinational read data |

## Verification
The host clear and a traffic event can land on the same clock edge. The bench provokes this by asserting the clear write in the cycle that accepts a single-beat picture packet, and again while a packet is held open. It expects a picture count of 1 and a duration of 1 rather than 0. A second collision is an abandoned descriptor packet followed directly by a new start-of-packet. There the bench checks that neither the descriptor count nor the captured resolution moves, while the new packet is still counted.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

    localparam int REG_W  = 32;
    localparam int RES_W  = 16;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = 4;

    localparam logic [NIB_W-1:0] CODE_PICTURE    = 4'h0;
    localparam logic [NIB_W-1:0] CODE_DESCRIPTOR = 4'hF;

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_PIC    = 3'd1;
    localparam logic [ADDR_W-1:0] A_DSC    = 3'd2;
    localparam logic [ADDR_W-1:0] A_RES    = 3'd3;
    localparam logic [ADDR_W-1:0] A_DUR    = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_PICTURE,
        PK_DESCRIPTOR
    } pkt_kind_e;

    typedef struct packed {
        logic [RES_W-1:0] height;
        logic [RES_W-1:0] width;
    } res_t;

    typedef struct packed {
        logic             take;
        logic             sop;
        logic             eop;
        logic [NIB_W-1:0] nib;
    } beat_t;

    function automatic pkt_kind_e kind_of(input logic [NIB_W-1:0] code);
        if (code == CODE_PICTURE)         return PK_PICTURE;
        else if (code == CODE_DESCRIPTOR) return PK_DESCRIPTOR;
        else                              return PK_NONE;
    endfunction

    // Beats 1..4 after the header fill width MS nibble first, 5..8 fill height.
    function automatic res_t place_nibble(input res_t cur, input logic [IDX_W-1:0] idx,
                                          input logic [NIB_W-1:0] nib);
        res_t r;
        int   k;
        r = cur;
        k = int'(idx);
        if (k >= 1 && k <= 4)
            r.width[(4 - k) * NIB_W +: NIB_W] = nib;
        else if (k >= 5 && k <= 8)
            r.height[(8 - k) * NIB_W +: NIB_W] = nib;
        return r;
    endfunction

endpackage

// File: rtl/lmon_sat_counter.sv
module lmon_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] nxt;

    // Clear first, then the event of the same cycle is applied on top.
    always_comb begin
        nxt = clr ? '0 : q;
        if (inc && nxt != CNT_MAX)
            nxt = nxt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q == CNT_MAX && inc && !clr) |=> (q == CNT_MAX)); // R10
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc) |=> (q == '0)); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && q != CNT_MAX) |=> (q == $past(q) + CNT_W'(1))); // R4
    AST_CLR_EVENT: assert property (@(posedge clk) disable iff (rst)
        (inc && clr) |=> (q == CNT_W'(1))); // R9

endmodule

// File: rtl/lmon_decode.sv
module lmon_decode
    import lmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t bt,
    output logic  open_o,
    output logic  sop_take,
    output logic  pic_done,
    output logic  dsc_done,
    output res_t  res_o
);

    logic             open_q;
    pkt_kind_e        kind_q;
    pkt_kind_e        cur_kind;
    logic [IDX_W-1:0] idx_q;
    res_t             shadow_q;
    res_t             shadow_n;
    res_t             res_q;
    logic             start;
    logic             cont;
    logic             closes;

    always_comb begin
        start    = bt.take && bt.sop;
        cont     = bt.take && !bt.sop && open_q;
        closes   = bt.take && bt.eop && (start || open_q);
        cur_kind = start ? kind_of(bt.nib) : kind_q;
        shadow_n = start ? '0 : shadow_q;
        if (cont && kind_q == PK_DESCRIPTOR)
            shadow_n = place_nibble(shadow_q, idx_q, bt.nib);
        pic_done = closes && (cur_kind == PK_PICTURE);
        dsc_done = closes && (cur_kind == PK_DESCRIPTOR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            kind_q   <= PK_NONE;
            idx_q    <= '0;
            shadow_q <= '0;
            res_q    <= '0;
        end else begin
            if (start) begin
                kind_q <= kind_of(bt.nib);
                idx_q  <= IDX_W'(1);
            end else if (cont && idx_q != '1) begin
                idx_q  <= idx_q + IDX_W'(1);
            end
            shadow_q <= shadow_n;
            if (closes)     open_q <= 1'b0;
            else if (start) open_q <= 1'b1;
            if (dsc_done)   res_q  <= shadow_n;
        end
    end

    assign open_o   = open_q;
    assign sop_take = start;
    assign res_o    = res_q;

    AST_OPEN_SET: assert property (@(posedge clk) disable iff (rst)
        (bt.take && bt.sop && !bt.eop) |=> open_q); // R6
    AST_OPEN_CLR: assert property (@(posedge clk) disable iff (rst)
        (bt.take && bt.eop) |=> !open_q); // R6
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dsc_done |=> $stable(res_q)); // R5
    AST_NO_TAKE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        !bt.take |-> (!pic_done && !dsc_done)); // R3

endmodule

// File: rtl/lmon_regmap.sv
module lmon_regmap
    import lmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              st_valid,
    input  logic              st_ready,
    input  logic              st_open,
    input  logic [CNT_W-1:0]  pic_cnt,
    input  logic [CNT_W-1:0]  dsc_cnt,
    input  logic [CNT_W-1:0]  dur_cnt,
    input  res_t              res,
    output logic [REG_W-1:0]  rdata,
    output logic              clr
);

    always_comb begin
        clr = reg_wr && (reg_addr == A_CLR);
        case (reg_addr)
            A_STATUS: rdata = REG_W'({st_open, st_ready, st_valid});
            A_PIC:    rdata = REG_W'(pic_cnt);
            A_DSC:    rdata = REG_W'(dsc_cnt);
            A_RES:    rdata = res;
            A_DUR:    rdata = REG_W'(dur_cnt);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/stream_link_monitor.sv
module stream_link_monitor
    import lmon_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_sop,
    input  logic              s_eop,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_sop,
    output logic              m_eop,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    output logic [31:0]       reg_rdata
);

    beat_t            bt;
    logic             open_w;
    logic             sop_take;
    logic             pic_done;
    logic             dsc_done;
    logic             clr;
    res_t             res_w;
    logic [CNT_W-1:0] pic_cnt;
    logic [CNT_W-1:0] dsc_cnt;
    logic [CNT_W-1:0] dur_cnt;

    // Transparent path, no registers.
    assign m_data  = s_data;
    assign m_valid = s_valid;
    assign m_sop   = s_sop;
    assign m_eop   = s_eop;
    assign s_ready = m_ready;

    always_comb begin
        bt.take = s_valid && m_ready;
        bt.sop  = s_sop;
        bt.eop  = s_eop;
        bt.nib  = s_data[NIB_W-1:0];
    end

    lmon_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .bt       (bt),
        .open_o   (open_w),
        .sop_take (sop_take),
        .pic_done (pic_done),
        .dsc_done (dsc_done),
        .res_o    (res_w)
    );

    lmon_sat_counter #(.CNT_W(CNT_W)) u_pic_cnt (
        .clk (clk), .rst (rst), .clr (clr), .inc (pic_done), .q (pic_cnt)
    );

    lmon_sat_counter #(.CNT_W(CNT_W)) u_dsc_cnt (
        .clk (clk), .rst (rst), .clr (clr), .inc (dsc_done), .q (dsc_cnt)
    );

    lmon_sat_counter #(.CNT_W(CNT_W)) u_dur_cnt (
        .clk (clk), .rst (rst), .clr (clr || sop_take),
        .inc (open_w && !sop_take), .q (dur_cnt)
    );

    lmon_regmap #(.CNT_W(CNT_W)) u_regmap (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .st_valid (s_valid),
        .st_ready (m_ready),
        .st_open  (open_w),
        .pic_cnt  (pic_cnt),
        .dsc_cnt  (dsc_cnt),
        .dur_cnt  (dur_cnt),
        .res      (res_w),
        .rdata    (reg_rdata),
        .clr      (clr)
    );

    AST_DUR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!open_w && !sop_take && !clr) |=> $stable(dur_cnt)); // R7
    AST_DUR_START: assert property (@(posedge clk) disable iff (rst)
        sop_take |=> (dur_cnt == '0)); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (pic_cnt == '0 && dsc_cnt == '0 && !open_w)); // R11

endmodule

// File: tb/stream_link_monitor_bench.sv
module stream_link_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] s_data;
    logic          s_valid, s_sop, s_eop;
    logic          s_ready;
    logic [DW-1:0] m_data;
    logic          m_valid, m_sop, m_eop;
    logic          m_ready;
    logic          reg_wr;
    logic [2:0]    reg_addr;
    logic [31:0]   reg_rdata;

    int checks   = 0;
    int failures = 0;
    int e_pic    = 0;
    int e_dsc    = 0;
    logic [31:0] e_res = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stream_link_monitor #(.DATA_W(DW), .CNT_W(CW)) u_stream_link_monitor (
        .clk (clk), .rst (rst),
        .s_data (s_data), .s_valid (s_valid), .s_ready (s_ready),
        .s_sop (s_sop), .s_eop (s_eop),
        .m_data (m_data), .m_valid (m_valid), .m_ready (m_ready),
        .m_sop (m_sop), .m_eop (m_eop),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_rdata (reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    function automatic int sat_inc(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // Inputs are driven just after a rising edge; the accepting edge follows.
    task automatic beat(input logic [DW-1:0] d, input logic sop, input logic eop);
        s_data = d; s_sop = sop; s_eop = eop; s_valid = 1'b1;
        #1;
        chk("R1 pass", {20'b0, m_data, m_valid, m_sop, m_eop, s_ready},
                       {20'b0, s_data, s_valid, s_sop, s_eop, m_ready});
        @(posedge clk); #1;
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    endtask

    function automatic logic [3:0] payload_nib(input int i, input logic [15:0] w,
                                               input logic [15:0] h);
        if (i >= 1 && i <= 4)      return w[(4 - i) * 4 +: 4];
        else if (i >= 5 && i <= 8) return h[(8 - i) * 4 +: 4];
        else                       return 4'h9;
    endfunction

    function automatic logic [31:0] model_res(input int len, input logic [15:0] w,
                                              input logic [15:0] h);
        logic [31:0] r;
        r = '0;
        for (int i = 1; i <= 8 && i < len; i++) begin
            if (i <= 4) r[(4 - i) * 4 +: 4] = w[(4 - i) * 4 +: 4];
            else        r[16 + (8 - i) * 4 +: 4] = h[(8 - i) * 4 +: 4];
        end
        return r;
    endfunction

    task automatic send_pkt(input logic [3:0] code, input int len,
                            input logic [15:0] w, input logic [15:0] h);
        for (int i = 0; i < len; i++) begin
            if (i == 0) beat({4'h5, code}, 1'b1, (len == 1));
            else        beat({4'(i), payload_nib(i, w, h)}, 1'b0, (i == len - 1));
        end
        if (code == 4'h0) e_pic = sat_inc(e_pic);
        if (code == 4'hF) begin
            e_dsc = sat_inc(e_dsc);
            e_res = model_res(len, w, h);
        end
    endtask

    task automatic check_model(input string tag);
        rd_chk(3'd1, {tag, " R4 picture count"}, 32'(e_pic));
        rd_chk(3'd2, {tag, " R4 descriptor count"}, 32'(e_dsc));
        rd_chk(3'd3, {tag, " R5 resolution"}, e_res);
    endtask

    task automatic write_reg(input logic [2:0] a);
        reg_addr = a; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; s_data = '0; s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
        m_ready = 1'b0; reg_wr = 1'b0; reg_addr = '0;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;

        // R11 reset state
        rd_chk(3'd0, "R11 status", 32'h0);
        rd_chk(3'd1, "R11 picture", 32'h0);
        rd_chk(3'd2, "R11 descriptor", 32'h0);
        rd_chk(3'd3, "R11 resolution", 32'h0);
        rd_chk(3'd4, "R11 duration", 32'h0);

        // R2 / R3: valid without ready is not a beat
        s_data = 8'h50; s_sop = 1'b1; s_eop = 1'b1; s_valid = 1'b1;
        rd_chk(3'd0, "R2 status valid-only", 32'h1);
        chk("R1 ready low", {31'b0, s_ready}, 32'h0);
        @(posedge clk); #1;
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
        rd_chk(3'd1, "R3 stalled beat ignored", 32'h0);
        m_ready = 1'b1;
        rd_chk(3'd0, "R2 status ready-only", 32'h2);

        // Sweep of types and lengths (R3, R4, R5)
        for (int len = 1; len <= 10; len++) begin
            for (int k = 0; k < 3; k++) begin
                logic [3:0]  code;
                logic [15:0] w, h;
                code = (k == 0) ? 4'h0 : (k == 1) ? 4'hF : 4'h6;
                w = 16'h1000 + 16'(len * 16'h0123);
                h = 16'h0800 + 16'(len * 16'h0211);
                send_pkt(code, len, w, h);
                check_model("sweep");
            end
        end
        rd_chk(3'd0, "R6 closed after sweep", 32'h2);

        // R10 saturation of packet counts
        for (int i = 0; i < 8; i++) send_pkt(4'h0, 2, 16'h0, 16'h0);
        rd_chk(3'd1, "R10 picture saturates", 32'(CMAX));
        chk("R10 model", 32'(e_pic), 32'(CMAX));

        // R8 clear and ignored writes
        write_reg(3'd5);
        e_pic = 0; e_dsc = 0;
        check_model("R8 clear");
        rd_chk(3'd4, "R8 duration cleared", 32'h0);
        send_pkt(4'h0, 1, 16'h0, 16'h0);
        write_reg(3'd1);
        rd_chk(3'd1, "R8 write elsewhere ignored", 32'h1);
        rd_chk(3'd5, "R8 clear address reads zero", 32'h0);
        rd_chk(3'd6, "R8 unused address reads zero", 32'h0);

        // R9 clear coinciding with a closing picture packet
        send_pkt(4'hF, 9, 16'hABCD, 16'h1234);
        reg_wr = 1'b1; reg_addr = 3'd5;
        beat(8'h50, 1'b1, 1'b1);
        reg_wr = 1'b0;
        e_pic = 1; e_dsc = 0;
        check_model("R9 clear with event");

        // R6 / R5 abandoned descriptor packet
        beat(8'h5F, 1'b1, 1'b0);
        beat(8'h17, 1'b0, 1'b0);
        beat(8'h27, 1'b0, 1'b0);
        rd_chk(3'd0, "R6 open flag set", 32'h6);
        send_pkt(4'h0, 1, 16'h0, 16'h0);
        rd_chk(3'd0, "R6 restart closes", 32'h2);
        check_model("R5 abandoned descriptor");

        // R4 stray end-of-packet with no packet open
        beat(8'h50, 1'b0, 1'b1);
        rd_chk(3'd1, "R4 stray eop ignored", 32'(e_pic));

        // R7 duration
        beat(8'h50, 1'b1, 1'b0);
        rd_chk(3'd4, "R7 duration at start", 32'h0);
        repeat (5) @(posedge clk); #1;
        rd_chk(3'd4, "R7 duration counts", 32'h5);
        beat(8'h51, 1'b0, 1'b1);
        e_pic = sat_inc(e_pic);
        rd_chk(3'd4, "R7 closing edge counted", 32'h6);
        repeat (3) @(posedge clk); #1;
        rd_chk(3'd4, "R7 duration holds", 32'h6);

        // R10 duration saturation, R9 clear while open
        beat(8'h50, 1'b1, 1'b0);
        repeat (20) @(posedge clk); #1;
        rd_chk(3'd4, "R10 duration saturates", 32'(CMAX));
        write_reg(3'd5);
        rd_chk(3'd4, "R9 clear while open", 32'h1);
        beat(8'h51, 1'b0, 1'b1);
        rd_chk(3'd1, "R8 count after clear", 32'h1);
        rd_chk(3'd0, "R6 closed", 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule